// File: doc/BRIEF.md
# Tile-Sparse Shared-Vector Dot Product Unit

This block computes one rank step of a low-rank product for several independent input vectors at once. Each of `N_IN` input vectors is held in a small on-chip buffer and is divided into `N_TILES` tiles of `TILE_LEN` signed 16-bit elements. A shared left vector has been pruned tile-wise, so only `N_KEEP` of its tiles survive. Those tiles arrive one per beat on a valid/ready stream and go to every input unit at the same time. For each rank, a list of surviving tile numbers selects which tile of each input buffer meets each incoming weight tile. Each unit has one multiply-accumulate lane per surviving tile and an adder tree that reduces the lanes. Each unit then multiplies its sum by a per-input, per-rank scale factor.

Software first fills the input buffers, the scale table and the tile-number table through plain write ports, then pulses `start`. The block walks through ranks `0 .. N_RANK-1` in order. For each rank it takes exactly `N_KEEP` weight beats and then emits `N_IN` scaled scalars on the output stream. When the last scalar of the last rank has been accepted, it raises `done` for one cycle. Back-pressure on the output stream stalls the sequence: no weight beat of the next rank is accepted until every result of the current rank has been taken. A beat on either stream transfers on a rising clock edge at which both valid and ready are high.

Top module: `tile_dot_engine`

## Requirements
- R1: After reset, `o_valid`, `w_ready` and `done` are low. `w_ready` stays low until a `start` pulse arrives.
- R2: For each rank the block accepts exactly `N_KEEP` weight beats. Beat k (counting from 0) carries weight tile k, with element e in bits `[e*16 +: 16]` of `w_data`. It pairs with input tile `list[rank][k]`, which covers elements `list*TILE_LEN .. list*TILE_LEN+TILE_LEN-1` of each buffer.
- R3: The unscaled value for input j and rank r is the signed sum over k and e of `x_j[list[r][k]*TILE_LEN+e] * w_k[e]`. Buffer tiles that are not in the list have no effect on any output.
- R4: Each output equals the unscaled value times the 16-bit signed scale written for that input and rank. It is exact to full width with no overflow, even when every operand is -32768.
- R5: Outputs appear rank by rank in ascending order, and within a rank by input index 0 .. N_IN-1. `o_input` and `o_rank` give the input and rank of the current `o_data`.
- R6: While `o_valid` is high and `o_ready` is low, `o_valid` stays high and `o_data`, `o_input` and `o_rank` hold their values.
- R7: `w_ready` is low during every cycle in which `o_valid` is high. The first beat of a rank is not accepted until all results of the previous rank have been accepted.
- R8: `done` is high for exactly one cycle, namely the cycle after the handshake of the output for input N_IN-1 of rank N_RANK-1. Each start yields exactly N_IN×N_RANK outputs.
- R9: A `start` pulse while a run is in progress is ignored. It neither restarts the run nor adds outputs, and after `done` the block waits with `w_ready` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run over all ranks (ignored when busy) |
| xw_en | input | 1 | Input buffer write strobe |
| xw_sel | input | 2 | Input buffer number |
| xw_addr | input | 4 | Element address inside the buffer |
| xw_data | input | 16 | Signed element value |
| sw_en | input | 1 | Scale table write strobe |
| sw_sel | input | 2 | Input number of the scale |
| sw_rank | input | 2 | Rank of the scale |
| sw_data | input | 16 | Signed scale value |
| iw_en | input | 1 | Tile list write strobe |
| iw_rank | input | 2 | Rank of the list entry |
| iw_slot | input | 1 | Slot k in the list |
| iw_tile | input | 2 | Tile number stored at that slot |
| w_valid | input | 1 | Weight tile valid |
| w_ready | output | 1 | Weight tile ready |
| w_data | input | 64 | Packed weight tile |
| o_valid | output | 1 | Result valid |
| o_ready | input | 1 | Result ready |
| o_data | output | 52 | Signed scaled result |
| o_input | output | 2 | Input index of the result |
| o_rank | output | 2 | Rank of the result |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The assertions check on every cycle the rules of the output stream: values hold while the output is stalled, results within a rank follow one another in input order, and weight acceptance and result emission never overlap. They also check that `done` is a single-cycle pulse caused by the final output handshake, and that lane and result registers change only when enabled. The arithmetic itself can only be shown by the bench's scenarios. These pair each listed tile with the right buffer tile, place deliberately non-zero data in pruned tiles, repeat and reorder tile numbers, use extreme operands, and apply gaps and random stalls on both streams. The bench also issues a `start` during a run and checks that the output count is unchanged.

// File: rtl/tdp_pkg.sv
package tdp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOAD,
    ST_SUM,
    ST_EMIT
  } tdp_state_e;

  // width of one lane sum: a full product plus growth over one tile
  function automatic int lane_width(input int dw, input int tile_len);
    return 2 * dw + $clog2(tile_len) + 1;
  endfunction

  // width after the adder tree over all kept lanes
  function automatic int dot_width(input int dw, input int tile_len, input int n_keep);
    return lane_width(dw, tile_len) + $clog2(n_keep);
  endfunction

  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/tdp_lane.sv
module tdp_lane import tdp_pkg::*; #(
  parameter int DW       = 16,
  parameter int TILE_LEN = 4,
  parameter int N_TILES  = 4,
  localparam int X_BITS  = N_TILES * TILE_LEN * DW,
  localparam int TSEL_W  = idx_width(N_TILES),
  localparam int LANE_W  = lane_width(DW, TILE_LEN)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic [TSEL_W-1:0]        tile_sel,
  input  logic [X_BITS-1:0]        x_flat,
  input  logic [TILE_LEN*DW-1:0]   w_tile,
  output logic signed [LANE_W-1:0] acc
);

  logic signed [DW-1:0]     xe [TILE_LEN];
  logic signed [DW-1:0]     we [TILE_LEN];
  logic signed [2*DW-1:0]   pr [TILE_LEN];
  logic signed [LANE_W-1:0] tile_sum;

  always_comb begin
    tile_sum = '0;
    for (int e = 0; e < TILE_LEN; e++) begin
      xe[e] = x_flat[(int'(tile_sel) * TILE_LEN + e) * DW +: DW];
      we[e] = w_tile[e * DW +: DW];
      pr[e] = xe[e] * we[e];
      tile_sum = tile_sum + LANE_W'(pr[e]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) acc <= '0;
    else if (en) acc <= tile_sum;
  end

  // R2: a lane changes only on the beat that belongs to it
  a_r2_lane_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(acc));

endmodule

// File: rtl/tdp_unit.sv
module tdp_unit import tdp_pkg::*; #(
  parameter int DW       = 16,
  parameter int TILE_LEN = 4,
  parameter int N_TILES  = 4,
  parameter int N_KEEP   = 2,
  parameter int N_RANK   = 3,
  localparam int X_LEN   = N_TILES * TILE_LEN,
  localparam int XA_W    = idx_width(X_LEN),
  localparam int TSEL_W  = idx_width(N_TILES),
  localparam int RK_W    = idx_width(N_RANK),
  localparam int LANE_W  = lane_width(DW, TILE_LEN),
  localparam int DOT_W   = dot_width(DW, TILE_LEN, N_KEEP),
  localparam int OUT_W   = DOT_W + DW
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      xw_en,
  input  logic [XA_W-1:0]           xw_addr,
  input  logic [DW-1:0]             xw_data,
  input  logic                      sw_en,
  input  logic [RK_W-1:0]           sw_rank,
  input  logic [DW-1:0]             sw_data,
  input  logic [RK_W-1:0]           rank,
  input  logic [N_KEEP*TSEL_W-1:0]  tile_list,
  input  logic [TILE_LEN*DW-1:0]    w_tile,
  input  logic [N_KEEP-1:0]         lane_en,
  input  logic                      sum_en,
  output logic signed [OUT_W-1:0]   result
);

  logic [X_LEN*DW-1:0]      x_flat;
  logic signed [DW-1:0]     scale_mem [N_RANK];
  logic signed [LANE_W-1:0] lane_acc [N_KEEP];
  logic signed [DOT_W-1:0]  tree_sum;

  // input vector buffer
  always_ff @(posedge clk) begin
    if (!rst_n) x_flat <= '0;
    else if (xw_en) x_flat[int'(xw_addr) * DW +: DW] <= xw_data;
  end

  // per-rank scale factors of this input
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < N_RANK; r++) scale_mem[r] <= '0;
    end else if (sw_en) begin
      scale_mem[sw_rank] <= sw_data;
    end
  end

  for (genvar k = 0; k < N_KEEP; k++) begin : g_lane
    tdp_lane #(
      .DW(DW), .TILE_LEN(TILE_LEN), .N_TILES(N_TILES)
    ) u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (lane_en[k]),
      .tile_sel(tile_list[k*TSEL_W +: TSEL_W]),
      .x_flat  (x_flat),
      .w_tile  (w_tile),
      .acc     (lane_acc[k])
    );
  end

  // reduction of all kept lanes
  always_comb begin
    tree_sum = '0;
    for (int k = 0; k < N_KEEP; k++) tree_sum = tree_sum + DOT_W'(lane_acc[k]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) result <= '0;
    else if (sum_en) result <= OUT_W'(tree_sum) * OUT_W'(scale_mem[rank]);
  end

  // R4: the scaled result register only moves on the sum step
  a_r4_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sum_en |=> $stable(result));

endmodule

// File: rtl/tile_dot_engine.sv
module tile_dot_engine import tdp_pkg::*; #(
  parameter int N_IN     = 3,
  parameter int DW       = 16,
  parameter int TILE_LEN = 4,
  parameter int N_TILES  = 4,
  parameter int N_KEEP   = 2,
  parameter int N_RANK   = 3,
  localparam int IN_W    = idx_width(N_IN),
  localparam int XA_W    = idx_width(N_TILES * TILE_LEN),
  localparam int RK_W    = idx_width(N_RANK),
  localparam int SL_W    = idx_width(N_KEEP),
  localparam int TSEL_W  = idx_width(N_TILES),
  localparam int OUT_W   = dot_width(DW, TILE_LEN, N_KEEP) + DW
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic                    xw_en,
  input  logic [IN_W-1:0]         xw_sel,
  input  logic [XA_W-1:0]         xw_addr,
  input  logic [DW-1:0]           xw_data,
  input  logic                    sw_en,
  input  logic [IN_W-1:0]         sw_sel,
  input  logic [RK_W-1:0]         sw_rank,
  input  logic [DW-1:0]           sw_data,
  input  logic                    iw_en,
  input  logic [RK_W-1:0]         iw_rank,
  input  logic [SL_W-1:0]         iw_slot,
  input  logic [TSEL_W-1:0]       iw_tile,
  input  logic                    w_valid,
  output logic                    w_ready,
  input  logic [TILE_LEN*DW-1:0]  w_data,
  output logic                    o_valid,
  input  logic                    o_ready,
  output logic [OUT_W-1:0]        o_data,
  output logic [IN_W-1:0]         o_input,
  output logic [RK_W-1:0]         o_rank,
  output logic                    done
);

  tdp_state_e              state;
  logic [SL_W-1:0]         beat;
  logic [RK_W-1:0]         rank_q;
  logic [IN_W-1:0]         out_idx;
  logic [TSEL_W-1:0]       list_tab [N_RANK][N_KEEP];
  logic [N_KEEP*TSEL_W-1:0] list_cur;
  logic [N_KEEP-1:0]       lane_en;
  logic                    w_fire;
  logic                    o_fire;
  logic signed [OUT_W-1:0] res [N_IN];

  assign w_ready = (state == ST_LOAD);
  assign o_valid = (state == ST_EMIT);
  assign w_fire  = w_valid && w_ready;
  assign o_fire  = o_valid && o_ready;
  assign o_data  = res[out_idx];
  assign o_input = out_idx;
  assign o_rank  = rank_q;

  // tile-number lists, one per rank
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < N_RANK; r++)
        for (int k = 0; k < N_KEEP; k++) list_tab[r][k] <= '0;
    end else if (iw_en) begin
      list_tab[iw_rank][iw_slot] <= iw_tile;
    end
  end

  always_comb begin
    for (int k = 0; k < N_KEEP; k++) begin
      list_cur[k*TSEL_W +: TSEL_W] = list_tab[rank_q][k];
      lane_en[k] = w_fire && (beat == SL_W'(k));
    end
  end

  // sequencing over beats, ranks and outputs
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      beat    <= '0;
      rank_q  <= '0;
      out_idx <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          state  <= ST_LOAD;
          rank_q <= '0;
          beat   <= '0;
        end
        ST_LOAD: if (w_fire) begin
          if (beat == SL_W'(N_KEEP - 1)) begin
            beat  <= '0;
            state <= ST_SUM;
          end else begin
            beat <= beat + 1'b1;
          end
        end
        ST_SUM: begin
          out_idx <= '0;
          state   <= ST_EMIT;
        end
        ST_EMIT: if (o_ready) begin
          if (out_idx == IN_W'(N_IN - 1)) begin
            out_idx <= '0;
            if (rank_q == RK_W'(N_RANK - 1)) begin
              state <= ST_IDLE;
              done  <= 1'b1;
            end else begin
              rank_q <= rank_q + 1'b1;
              state  <= ST_LOAD;
            end
          end else begin
            out_idx <= out_idx + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  for (genvar j = 0; j < N_IN; j++) begin : g_unit
    tdp_unit #(
      .DW(DW), .TILE_LEN(TILE_LEN), .N_TILES(N_TILES),
      .N_KEEP(N_KEEP), .N_RANK(N_RANK)
    ) u_unit (
      .clk      (clk),
      .rst_n    (rst_n),
      .xw_en    (xw_en && (xw_sel == IN_W'(j))),
      .xw_addr  (xw_addr),
      .xw_data  (xw_data),
      .sw_en    (sw_en && (sw_sel == IN_W'(j))),
      .sw_rank  (sw_rank),
      .sw_data  (sw_data),
      .rank     (rank_q),
      .tile_list(list_cur),
      .w_tile   (w_data),
      .lane_en  (lane_en),
      .sum_en   (state == ST_SUM),
      .result   (res[j])
    );
  end

  // R6: a stalled result holds
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && !o_ready) |=> (o_valid && $stable(o_data) && $stable(o_input) && $stable(o_rank)));

  // R5: within a rank the next input follows directly
  a_r5_next_input: assert property (@(posedge clk) disable iff (!rst_n)
    (o_fire && o_input != IN_W'(N_IN - 1)) |=>
      (o_valid && o_input == IN_W'($past(o_input) + 1'b1) && $stable(o_rank)));

  // R7: weights and results never move in the same cycle
  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    o_valid |-> !w_ready);

  // R2: beat counter never passes the kept tile count
  a_r2_beat_range: assert property (@(posedge clk) disable iff (!rst_n)
    w_ready |-> (int'(beat) < N_KEEP));

  // R8: done is a single pulse
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: done follows the final output handshake
  a_r8_done_cause: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(o_fire && o_rank == RK_W'(N_RANK - 1) && o_input == IN_W'(N_IN - 1)));

endmodule

// File: tb/sim_tile_dot_engine.sv
`timescale 1ns/1ps
module sim_tile_dot_engine;

  localparam int N_IN = 3, DW = 16, TILE_LEN = 4, N_TILES = 4, N_KEEP = 2, N_RANK = 3;
  localparam int X_LEN = N_TILES * TILE_LEN;
  localparam int OUT_W = 52;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic xw_en = 1'b0;  logic [1:0] xw_sel = '0; logic [3:0] xw_addr = '0; logic [15:0] xw_data = '0;
  logic sw_en = 1'b0;  logic [1:0] sw_sel = '0; logic [1:0] sw_rank = '0; logic [15:0] sw_data = '0;
  logic iw_en = 1'b0;  logic [1:0] iw_rank = '0; logic [0:0] iw_slot = '0; logic [1:0] iw_tile = '0;
  logic w_valid = 1'b0; logic w_ready; logic [TILE_LEN*DW-1:0] w_data = '0;
  logic o_valid; logic o_ready = 1'b1; logic [OUT_W-1:0] o_data;
  logic [1:0] o_input; logic [1:0] o_rank; logic done;

  always #2.5 clk = ~clk;

  tile_dot_engine #(
    .N_IN(N_IN), .DW(DW), .TILE_LEN(TILE_LEN), .N_TILES(N_TILES), .N_KEEP(N_KEEP), .N_RANK(N_RANK)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .start(start),
    .xw_en(xw_en), .xw_sel(xw_sel), .xw_addr(xw_addr), .xw_data(xw_data),
    .sw_en(sw_en), .sw_sel(sw_sel), .sw_rank(sw_rank), .sw_data(sw_data),
    .iw_en(iw_en), .iw_rank(iw_rank), .iw_slot(iw_slot), .iw_tile(iw_tile),
    .w_valid(w_valid), .w_ready(w_ready), .w_data(w_data),
    .o_valid(o_valid), .o_ready(o_ready), .o_data(o_data),
    .o_input(o_input), .o_rank(o_rank), .done(done)
  );

  int total = 0;
  int fails = 0;

  int xv [N_IN][X_LEN];
  int scv [N_IN][N_RANK];
  int lst [N_RANK][N_KEEP];
  int wv [N_RANK][N_KEEP][TILE_LEN];

  longint exp_val[$];
  int     exp_in[$];
  int     exp_rk[$];

  bit exp_done = 1'b0;
  bit run_done = 1'b0;
  bit bp_mode = 1'b0;
  int rdy_cnt = 0;
  bit held = 1'b0;
  logic [OUT_W-1:0] h_data; logic [1:0] h_in; logic [1:0] h_rk;

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // output ready pattern, changed away from the sampling edge
  always @(posedge clk) begin
    #1;
    rdy_cnt++;
    o_ready = bp_mode ? ((rdy_cnt % 3) != 0 && (rdy_cnt % 7) != 2) : 1'b1;
  end

  // reference comparison on every clock
  always @(negedge clk) begin
    if (rst_n) begin
      bit popped;
      popped = 1'b0;
      if (done || exp_done) chk(done == exp_done, "R8 done timing", done, exp_done);
      if (done) run_done = 1'b1;
      if (held) begin
        chk(o_valid && o_data == h_data && o_input == h_in && o_rank == h_rk,
            "R6 stall hold", longint'($signed(o_data)), longint'($signed(h_data)));
      end
      held = 1'b0;
      if (o_valid) chk(!w_ready, "R7 ready while emitting", w_ready, 0);
      if (o_valid && o_ready) begin
        if (exp_val.size() == 0) begin
          chk(1'b0, "R8 extra output", 1, 0);
        end else begin
          longint ev; int ei; int er;
          ev = exp_val.pop_front(); ei = exp_in.pop_front(); er = exp_rk.pop_front();
          chk(longint'($signed(o_data)) == ev, "R3 R4 value", longint'($signed(o_data)), ev);
          chk(int'(o_input) == ei && int'(o_rank) == er, "R5 order",
              int'(o_rank) * 10 + int'(o_input), er * 10 + ei);
          popped = (exp_val.size() == 0);
        end
      end else if (o_valid) begin
        held = 1'b1; h_data = o_data; h_in = o_input; h_rk = o_rank;
      end
      exp_done = popped;
    end
  end

  task automatic wr_x(input int j, input int a, input int v);
    @(negedge clk);
    xw_en = 1; xw_sel = 2'(j); xw_addr = 4'(a); xw_data = 16'(v);
    @(negedge clk); xw_en = 0;
  endtask

  task automatic wr_s(input int j, input int r, input int v);
    @(negedge clk);
    sw_en = 1; sw_sel = 2'(j); sw_rank = 2'(r); sw_data = 16'(v);
    @(negedge clk); sw_en = 0;
  endtask

  task automatic wr_l(input int r, input int k, input int t);
    @(negedge clk);
    iw_en = 1; iw_rank = 2'(r); iw_slot = 1'(k); iw_tile = 2'(t);
    @(negedge clk); iw_en = 0;
  endtask

  task automatic load_all();
    for (int j = 0; j < N_IN; j++) begin
      for (int a = 0; a < X_LEN; a++) wr_x(j, a, xv[j][a]);
      for (int r = 0; r < N_RANK; r++) wr_s(j, r, scv[j][r]);
    end
    for (int r = 0; r < N_RANK; r++)
      for (int k = 0; k < N_KEEP; k++) wr_l(r, k, lst[r][k]);
  endtask

  task automatic build_expect();
    for (int r = 0; r < N_RANK; r++)
      for (int j = 0; j < N_IN; j++) begin
        longint acc;
        acc = 0;
        for (int k = 0; k < N_KEEP; k++)
          for (int e = 0; e < TILE_LEN; e++)
            acc += longint'(xv[j][lst[r][k] * TILE_LEN + e]) * longint'(wv[r][k][e]);
        exp_val.push_back(acc * longint'(scv[j][r]));
        exp_in.push_back(j);
        exp_rk.push_back(r);
      end
  endtask

  task automatic drive_weights(input int gap);
    for (int r = 0; r < N_RANK; r++)
      for (int k = 0; k < N_KEEP; k++) begin
        bit ok;
        if (gap > 0) begin
          w_valid = 0;
          repeat (gap) @(negedge clk);
        end
        w_valid = 1;
        for (int e = 0; e < TILE_LEN; e++) w_data[e*DW +: DW] = 16'(wv[r][k][e]);
        ok = 1'b0;
        while (!ok) begin
          ok = w_ready;
          @(negedge clk);
        end
      end
    w_valid = 0;
  endtask

  task automatic run(input int gap, input bit extra_start);
    build_expect();
    run_done = 1'b0;
    @(negedge clk);
    start = 1;
    @(negedge clk);
    start = 0;
    fork
      drive_weights(gap);
      begin
        if (extra_start) begin
          repeat (3) @(negedge clk);
          start = 1;              // R9: while busy
          @(negedge clk);
          start = 0;
        end
      end
    join
    wait (run_done);
    @(negedge clk);
    @(negedge clk);
    chk(exp_val.size() == 0, "R8 output count", exp_val.size(), 0);
    chk(!w_ready && !o_valid, "R9 idle after done", w_ready, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!o_valid, "R1 o_valid reset", o_valid, 0);
    chk(!w_ready, "R1 w_ready reset", w_ready, 0);
    chk(!done, "R1 done reset", done, 0);
    w_valid = 1;
    repeat (4) @(negedge clk);
    chk(!w_ready, "R1 no ready before start", w_ready, 0);
    w_valid = 0;

    // scenario 1: pruned tiles carry large data, no stalls
    for (int j = 0; j < N_IN; j++) begin
      for (int a = 0; a < X_LEN; a++) xv[j][a] = (j + 1) * 7 + a * 3 - 20;
      for (int r = 0; r < N_RANK; r++) scv[j][r] = j * 3 - r * 2 - 1;
    end
    lst[0][0] = 1; lst[0][1] = 3;
    lst[1][0] = 2; lst[1][1] = 0;
    lst[2][0] = 3; lst[2][1] = 3;
    for (int r = 0; r < N_RANK; r++)
      for (int k = 0; k < N_KEEP; k++)
        for (int e = 0; e < TILE_LEN; e++) wv[r][k][e] = r * 5 + k * 3 + e * 2 - 6;
    load_all();
    run(0, 1'b0);

    // scenario 2: new lists and scales, output stalls, weight gaps, stray start
    bp_mode = 1'b1;
    lst[0][0] = 0; lst[0][1] = 2;
    lst[1][0] = 3; lst[1][1] = 1;
    lst[2][0] = 1; lst[2][1] = 0;
    for (int j = 0; j < N_IN; j++)
      for (int r = 0; r < N_RANK; r++) scv[j][r] = 100 - 37 * j + 11 * r;
    for (int r = 0; r < N_RANK; r++)
      for (int k = 0; k < N_KEEP; k++)
        for (int e = 0; e < TILE_LEN; e++) wv[r][k][e] = (e + 1) * 1000 - r * 777 + k * 313;
    load_all();
    run(2, 1'b1);

    // scenario 3: extreme operands, overflow margin
    for (int j = 0; j < N_IN; j++) begin
      for (int a = 0; a < X_LEN; a++) xv[j][a] = -32768;
      for (int r = 0; r < N_RANK; r++) scv[j][r] = (j == 1) ? 32767 : -32768;
    end
    for (int r = 0; r < N_RANK; r++)
      for (int k = 0; k < N_KEEP; k++)
        for (int e = 0; e < TILE_LEN; e++) wv[r][k][e] = (r == 2 && e == 0) ? 32767 : -32768;
    load_all();
    run(1, 1'b0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule